// File: doc/BRIEF.md
# Byte Bit-Manipulation and Bit-Test Unit

This unit carries out the CMOS-era single-byte bit operations for an 8-bit processor core. The core's sequencer has already fetched the operand byte from memory. The unit receives that byte together with the opcode, the accumulator, the current N, V and Z flags and a branch target that the address logic has already worked out. One clock later it returns four things: the byte to write back with a write strobe, the new N, V and Z values, and a decision on whether to branch, with the address to branch to.

It covers five groups of operations:
- masked test-and-clear and test-and-set against the accumulator;
- clearing or setting a single bit chosen by the opcode;
- branching on the state of a chosen bit;
- the BIT test in its memory forms;
- the BIT test in its immediate form, which changes only Z.

Opcodes outside these groups pass through untouched. The unit writes nothing, changes no flag and takes no branch for them. Memory sequencing and the decoding of every other opcode belong to the surrounding core.

Top module: `bitmod_unit`

## Requirements
- R1: While `rstN` is low and in the cycle after it rises, every output is 0.
- R2: Results appear exactly one clock after an operation is presented, and `resValid` goes high in that cycle. In a cycle where `opValid` was low, `resValid`, `wrEn` and `takeBranch` are 0, and `nOut`/`vOut`/`zOut` equal the flag inputs of that cycle.
- R3: Test-and-clear (opcodes 0x14 and 0x1C) writes `memByte & ~accByte` with `wrEn` high. It sets Z when `memByte & accByte` is zero and leaves N and V unchanged.
- R4: Test-and-set (opcodes 0x04 and 0x0C) writes `memByte | accByte` with `wrEn` high. It sets Z the same way as R3 and leaves N and V unchanged.
- R5: Bit clear, opcode 0x07 + 0x10·k for k = 0..7, writes `memByte` with bit k cleared and `wrEn` high. The flags are unchanged and no branch is taken.
- R6: Bit set, opcode 0x87 + 0x10·k, writes `memByte` with bit k set and `wrEn` high. The flags are unchanged and no branch is taken.
- R7: Branch-if-clear, opcode 0x0F + 0x10·k, raises `takeBranch` with `branchAddr` = `branchTarget` exactly when bit k of `memByte` is 0. When the test fails, `takeBranch` is 0 and `branchAddr` is 0. A branch opcode never raises `wrEn`, and the flags are unchanged.
- R8: Branch-if-set, opcode 0x8F + 0x10·k, behaves as in R7 but branches when bit k is 1.
- R9: BIT in its memory forms (opcodes 0x24, 0x2C, 0x34, 0x3C) sets Z from `memByte & accByte`, copies `memByte` bit 7 to N and bit 6 to V, and does not write.
- R10: BIT immediate (opcode 0x89) updates only Z. N and V keep their input values, and nothing is written.
- R11: Any other opcode gives `wrEn` 0, `takeBranch` 0 and flags equal to their inputs. Whenever no write happens, `wrData` carries `memByte` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Opcode of the operation |
| memByte | input | 8 | Operand byte read from memory (or the immediate) |
| accByte | input | 8 | Accumulator value |
| nIn | input | 1 | Current N flag |
| vIn | input | 1 | Current V flag |
| zIn | input | 1 | Current Z flag |
| branchTarget | input | 16 | Precomputed relative-branch destination |
| resValid | output | 1 | Result of the previous cycle's operation is valid |
| wrData | output | 8 | Byte to write back |
| wrEn | output | 1 | Write the byte back |
| nOut | output | 1 | New N flag |
| vOut | output | 1 | New V flag |
| zOut | output | 1 | New Z flag |
| takeBranch | output | 1 | Branch is taken |
| branchAddr | output | 16 | Branch destination (0 when not taken) |

## Verification
The bench sweeps all eight bit positions for the clear, set and both branch groups, and drives each branch with the bit at 0 and at 1. A decoder that used the wrong opcode nibble as the bit index, or inverted the branch polarity, would write the wrong bit or branch on the opposite condition. Each BIT immediate case is driven with N and V inputs that differ from bits 7 and 6 of the operand, so a design that treated it like the memory form would show changed N and V. The masked operations are driven with an empty AND, a full overlap and a partial overlap, so a Z computed from the result instead of from the AND would differ. Opcodes next to the decoded ones (0x03, 0x17 vs 0x13, 0x88, 0xEA), and handled opcodes with `opValid` low, must give no write, no branch and unchanged flags.

// File: rtl/bitmod_pkg.sv
package bitmod_pkg;

  localparam int SEL_W = 3;

  // Strobes from the opcode decoder to the datapath
  typedef struct packed {
    logic             isTrb;      // test-and-clear against accumulator
    logic             isTsb;      // test-and-set against accumulator
    logic             isBitWr;    // single-bit clear/set
    logic             isBranch;   // branch on single bit
    logic             polarity;   // 1: set / branch-if-set, 0: clear / branch-if-clear
    logic             isBitTest;  // BIT test
    logic             isImm;      // BIT immediate form
    logic [SEL_W-1:0] bitSel;     // selected bit position
  } bitmod_ctl_t;

endpackage

// File: rtl/bitmod_ctrl.sv
module bitmod_ctrl
  import bitmod_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            opValid,
  input  logic [OP_W-1:0] opcode,
  output bitmod_ctl_t     ctl
);

  localparam logic [3:0] NIB_BITWR  = 4'h7;
  localparam logic [3:0] NIB_BRANCH = 4'hF;

  logic [3:0] lowNib;
  assign lowNib = opcode[3:0];

  always_comb begin
    ctl = '0;
    ctl.bitSel   = opcode[6:4];
    ctl.polarity = opcode[7];
    if (opValid) begin
      case (opcode)
        8'h14, 8'h1C: ctl.isTrb = 1'b1;
        8'h04, 8'h0C: ctl.isTsb = 1'b1;
        8'h24, 8'h2C, 8'h34, 8'h3C: ctl.isBitTest = 1'b1;
        8'h89: begin
          ctl.isBitTest = 1'b1;
          ctl.isImm     = 1'b1;
        end
        default: begin
          ctl.isBitWr  = (lowNib == NIB_BITWR);
          ctl.isBranch = (lowNib == NIB_BRANCH);
        end
      endcase
    end
  end

endmodule

// File: rtl/bitmod_dp.sv
module bitmod_dp
  import bitmod_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  bitmod_ctl_t       ctl,
  input  logic [DATA_W-1:0] memByte,
  input  logic [DATA_W-1:0] accByte,
  input  logic              nIn,
  input  logic              vIn,
  input  logic              zIn,
  input  logic [ADDR_W-1:0] branchTarget,
  output logic              resValid,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              nOut,
  output logic              vOut,
  output logic              zOut,
  output logic              takeBranch,
  output logic [ADDR_W-1:0] branchAddr
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] andVal;
  logic              andZero;
  logic              selBit;
  logic [DATA_W-1:0] nxtData;
  logic              nxtWe;
  logic              nxtN, nxtV, nxtZ;
  logic              nxtTake;

  // One-hot mask of the selected bit
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign bitMask[g] = (ctl.bitSel == SEL_W'(g));
  end

  assign andVal  = memByte & accByte;
  assign andZero = (andVal == '0);
  assign selBit  = |(memByte & bitMask);

  always_comb begin
    nxtData = memByte;
    nxtWe   = 1'b0;
    nxtN    = nIn;
    nxtV    = vIn;
    nxtZ    = zIn;
    nxtTake = 1'b0;
    if (ctl.isTrb) begin
      nxtData = memByte & ~accByte;
      nxtWe   = 1'b1;
      nxtZ    = andZero;
    end else if (ctl.isTsb) begin
      nxtData = memByte | accByte;
      nxtWe   = 1'b1;
      nxtZ    = andZero;
    end else if (ctl.isBitWr) begin
      nxtData = ctl.polarity ? (memByte | bitMask) : (memByte & ~bitMask);
      nxtWe   = 1'b1;
    end else if (ctl.isBranch) begin
      nxtTake = (selBit == ctl.polarity);
    end else if (ctl.isBitTest) begin
      nxtZ = andZero;
      if (!ctl.isImm) begin
        nxtN = memByte[MSB];
        nxtV = memByte[MSB-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      wrData     <= '0;
      wrEn       <= 1'b0;
      nOut       <= 1'b0;
      vOut       <= 1'b0;
      zOut       <= 1'b0;
      takeBranch <= 1'b0;
      branchAddr <= '0;
    end else begin
      resValid   <= opValid;
      wrData     <= nxtData;
      wrEn       <= nxtWe;
      nOut       <= nxtN;
      vOut       <= nxtV;
      zOut       <= nxtZ;
      takeBranch <= nxtTake;
      branchAddr <= nxtTake ? branchTarget : '0;
    end
  end

endmodule

// File: rtl/bitmod_unit.sv
module bitmod_unit
  import bitmod_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] memByte,
  input  logic [DATA_W-1:0] accByte,
  input  logic              nIn,
  input  logic              vIn,
  input  logic              zIn,
  input  logic [ADDR_W-1:0] branchTarget,
  output logic              resValid,
  output logic [DATA_W-1:0] wrData,
  output logic              wrEn,
  output logic              nOut,
  output logic              vOut,
  output logic              zOut,
  output logic              takeBranch,
  output logic [ADDR_W-1:0] branchAddr
);

  bitmod_ctl_t ctl;

  bitmod_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opValid (opValid),
    .opcode  (opcode),
    .ctl     (ctl)
  );

  bitmod_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .opValid      (opValid),
    .ctl          (ctl),
    .memByte      (memByte),
    .accByte      (accByte),
    .nIn          (nIn),
    .vIn          (vIn),
    .zIn          (zIn),
    .branchTarget (branchTarget),
    .resValid     (resValid),
    .wrData       (wrData),
    .wrEn         (wrEn),
    .nOut         (nOut),
    .vOut         (vOut),
    .zOut         (zOut),
    .takeBranch   (takeBranch),
    .branchAddr   (branchAddr)
  );

endmodule

// File: rtl/bitmod_chk.sv
module bitmod_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int OP_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] memByte,
  input logic              nIn,
  input logic              vIn,
  input logic              zIn,
  input logic [ADDR_W-1:0] branchTarget,
  input logic              resValid,
  input logic              wrEn,
  input logic              nOut,
  input logic              vOut,
  input logic              zOut,
  input logic              takeBranch,
  input logic [ADDR_W-1:0] branchAddr
);

  logic seenValid;
  always_ff @(posedge clk) begin
    if (!rstN) seenValid <= 1'b0;
    else       seenValid <= opValid;
  end

  // R2
  latency_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid == seenValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!wrEn && !takeBranch));

  // R7
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeBranch |-> !wrEn);

  // R7
  branch_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && opValid) |=> (!takeBranch || branchAddr == $past(branchTarget)));

  // R10
  bit_imm_nv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && opValid && opcode == 8'h89) |=>
      (nOut == $past(nIn) && vOut == $past(vIn) && !wrEn));

  // R9
  bit_mem_nv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && opValid && (opcode == 8'h24 || opcode == 8'h2C)) |=>
      (nOut == $past(memByte[DATA_W-1]) && vOut == $past(memByte[DATA_W-2])));

  // R5
  bitwr_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && opValid && opcode[3:0] == 4'h7) |=>
      (wrEn && nOut == $past(nIn) && vOut == $past(vIn) && zOut == $past(zIn)));

endmodule

bind bitmod_unit bitmod_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opcode       (opcode),
  .memByte      (memByte),
  .nIn          (nIn),
  .vIn          (vIn),
  .zIn          (zIn),
  .branchTarget (branchTarget),
  .resValid     (resValid),
  .wrEn         (wrEn),
  .nOut         (nOut),
  .vOut         (vOut),
  .zOut         (zOut),
  .takeBranch   (takeBranch),
  .branchAddr   (branchAddr)
);

// File: tb/bitmod_unit_bench.sv
module bitmod_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  memByte = '0;
  logic [7:0]  accByte = '0;
  logic        nIn = 1'b0, vIn = 1'b0, zIn = 1'b0;
  logic [15:0] branchTarget = '0;
  logic        resValid;
  logic [7:0]  wrData;
  logic        wrEn;
  logic        nOut, vOut, zOut;
  logic        takeBranch;
  logic [15:0] branchAddr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitmod_unit u_bitmod_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opcode(opcode),
    .memByte(memByte), .accByte(accByte), .nIn(nIn), .vIn(vIn), .zIn(zIn),
    .branchTarget(branchTarget), .resValid(resValid), .wrData(wrData),
    .wrEn(wrEn), .nOut(nOut), .vOut(vOut), .zOut(zOut),
    .takeBranch(takeBranch), .branchAddr(branchAddr)
  );

  typedef struct {
    logic        rv;
    logic [7:0]  wd;
    logic        we;
    logic        n, v, z;
    logic        tk;
    logic [15:0] ba;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] m,
                                 input logic [7:0] a, input logic n, input logic v,
                                 input logic z, input logic [15:0] t, input logic val);
    exp_t e;
    int k;
    int lo;
    e.rv = val; e.wd = m; e.we = 1'b0; e.n = n; e.v = v; e.z = z;
    e.tk = 1'b0; e.ba = 16'h0; e.tag = "R2";
    k  = (int'(op) >> 4) % 8;
    lo = int'(op) % 16;
    if (val) begin
      e.tag = "R11";
      if (op == 8'h14 || op == 8'h1C) begin
        e.tag = "R3"; e.we = 1'b1; e.wd = m & ~a; e.z = ((m & a) == 8'h00);
      end else if (op == 8'h04 || op == 8'h0C) begin
        e.tag = "R4"; e.we = 1'b1; e.wd = m | a; e.z = ((m & a) == 8'h00);
      end else if (op == 8'h24 || op == 8'h2C || op == 8'h34 || op == 8'h3C) begin
        e.tag = "R9"; e.z = ((m & a) == 8'h00); e.n = m[7]; e.v = m[6];
      end else if (op == 8'h89) begin
        e.tag = "R10"; e.z = ((m & a) == 8'h00);
      end else if (lo == 7) begin
        e.we = 1'b1;
        if (op >= 8'h80) begin e.tag = "R6"; e.wd = m | 8'(1 << k); end
        else begin e.tag = "R5"; e.wd = m & ~8'(1 << k); end
      end else if (lo == 15) begin
        e.tag = (op >= 8'h80) ? "R8" : "R7";
        if (((int'(m) >> k) % 2) == ((op >= 8'h80) ? 1 : 0)) begin
          e.tk = 1'b1; e.ba = t;
        end
      end
    end
    return e;
  endfunction

  task automatic compareOne();
    exp_t e;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    checks++;
    if (resValid !== e.rv || wrData !== e.wd || wrEn !== e.we || nOut !== e.n ||
        vOut !== e.v || zOut !== e.z || takeBranch !== e.tk || branchAddr !== e.ba) begin
      errors++;
      $display("FAIL %s: got rv=%b wd=%h we=%b nvz=%b%b%b tk=%b ba=%h exp rv=%b wd=%h we=%b nvz=%b%b%b tk=%b ba=%h",
               e.tag, resValid, wrData, wrEn, nOut, vOut, zOut, takeBranch, branchAddr,
               e.rv, e.wd, e.we, e.n, e.v, e.z, e.tk, e.ba);
    end
  endtask

  task automatic applyOp(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                         input logic n, input logic v, input logic z,
                         input logic [15:0] t, input logic val);
    @(negedge clk);
    compareOne();
    opValid = val; opcode = op; memByte = m; accByte = a;
    nIn = n; vIn = v; zIn = z; branchTarget = t;
    expQ.push_back(model(op, m, a, n, v, z, t, val));
  endtask

  task automatic checkReset(input string when);
    checks++;
    if (resValid !== 1'b0 || wrData !== 8'h00 || wrEn !== 1'b0 || nOut !== 1'b0 ||
        vOut !== 1'b0 || zOut !== 1'b0 || takeBranch !== 1'b0 || branchAddr !== 16'h0) begin
      errors++;
      $display("FAIL R1 (%s): got rv=%b wd=%h we=%b nvz=%b%b%b tk=%b ba=%h exp all zero",
               when, resValid, wrData, wrEn, nOut, vOut, zOut, takeBranch, branchAddr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with busy inputs
    opValid = 1'b1; opcode = 8'h87; memByte = 8'hFF; accByte = 8'hFF;
    nIn = 1'b1; vIn = 1'b1; zIn = 1'b1; branchTarget = 16'hBEEF;
    repeat (3) @(negedge clk);
    checkReset("during reset");
    opValid = 1'b0; opcode = 8'h00; memByte = 8'h00; accByte = 8'h00;
    nIn = 1'b0; vIn = 1'b0; zIn = 1'b0; branchTarget = 16'h0;
    rstN = 1'b1;
    @(negedge clk);
    checkReset("after release");

    // R3: test-and-clear, empty, full, partial overlap
    applyOp(8'h14, 8'hF0, 8'h0F, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1);
    applyOp(8'h1C, 8'hAA, 8'hAA, 1'b0, 1'b1, 1'b1, 16'h0, 1'b1);
    applyOp(8'h14, 8'h3C, 8'h0F, 1'b1, 1'b1, 1'b1, 16'h0, 1'b1);
    // R4: test-and-set
    applyOp(8'h04, 8'h00, 8'h81, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
    applyOp(8'h0C, 8'h81, 8'h01, 1'b1, 1'b0, 1'b1, 16'h0, 1'b1);
    applyOp(8'h04, 8'h55, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0, 1'b1);

    // R5, R6, R7, R8: all bit positions
    for (int k = 0; k < 8; k++) begin
      applyOp(8'(8'h07 + 16 * k), 8'hFF, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0, 1'b1);
      applyOp(8'(8'h87 + 16 * k), 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 16'h0, 1'b1);
      applyOp(8'(8'h0F + 16 * k), ~8'(1 << k), 8'h00, 1'b0, 1'b0, 1'b1, 16'(16'h1000 + k), 1'b1);
      applyOp(8'(8'h0F + 16 * k), 8'(1 << k), 8'h00, 1'b1, 1'b1, 1'b0, 16'(16'h2000 + k), 1'b1);
      applyOp(8'(8'h8F + 16 * k), 8'(1 << k), 8'h00, 1'b0, 1'b1, 1'b1, 16'(16'h3000 + k), 1'b1);
      applyOp(8'(8'h8F + 16 * k), ~8'(1 << k), 8'h00, 1'b1, 1'b0, 1'b0, 16'(16'h4000 + k), 1'b1);
    end

    // R9: BIT memory forms
    applyOp(8'h24, 8'hC0, 8'h3F, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
    applyOp(8'h2C, 8'h41, 8'h01, 1'b1, 1'b0, 1'b1, 16'h0, 1'b1);
    applyOp(8'h34, 8'h80, 8'h80, 1'b0, 1'b1, 1'b1, 16'h0, 1'b1);
    applyOp(8'h3C, 8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1);
    // R10: BIT immediate, N/V inputs opposite to operand bits 7/6
    applyOp(8'h89, 8'hC0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
    applyOp(8'h89, 8'h3F, 8'h01, 1'b1, 1'b1, 1'b1, 16'h0, 1'b1);

    // R11: neighbouring and unrelated opcodes
    applyOp(8'h03, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 16'h5555, 1'b1);
    applyOp(8'h13, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 16'h5555, 1'b1);
    applyOp(8'h88, 8'h5A, 8'hA5, 1'b1, 1'b1, 1'b0, 16'h5555, 1'b1);
    applyOp(8'hEA, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'h5555, 1'b1);
    applyOp(8'h0E, 8'h01, 8'h01, 1'b1, 1'b0, 1'b0, 16'h5555, 1'b1);

    // R2: handled opcodes with opValid low
    applyOp(8'h87, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 16'h6666, 1'b0);
    applyOp(8'h0F, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0, 16'h6666, 1'b0);
    applyOp(8'h14, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 16'h6666, 1'b0);

    // Mixed stream of all groups, back to back
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      case ($urandom % 8)
        0: op = 8'h14;
        1: op = 8'h0C;
        2: op = 8'(8'h07 + 16 * ($urandom % 16));
        3: op = 8'(8'h0F + 16 * ($urandom % 16));
        4: op = 8'h2C;
        5: op = 8'h89;
        default: op = 8'($urandom);
      endcase
      applyOp(op, 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              16'($urandom), ($urandom % 5) != 0);
    end
    applyOp(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    compareOne();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule